// File: doc/BRIEF.md
# Chained Decimal and Binary Adder with Sticky Zero

This unit performs one step of a multi-precision addition. Each accepted request adds a source operand, a destination operand and an incoming extend bit, and returns the sum together with a fresh set of condition flags: extend, negative, zero, overflow and carry. In binary mode the addition is done at byte, word or longword width. In decimal mode the low byte of each operand holds two packed BCD digits, and the unit returns the decimal sum of those two digits plus the extend bit.

Software builds long numbers by feeding the unit one element at a time, least significant element first. It returns the outgoing extend flag and zero flag as the incoming flags of the next step. The zero flag can only be cleared, never set. This lets a chain that starts with zero set report at the end whether the whole wide result is zero. The destination bits above the selected width pass through unchanged, so the result can be written back to a full register.

Each request is registered once. Its result and flags appear on the outputs one clock after it is accepted, and they hold until the next request.

Top module: `xadd_unit`

## Requirements
- R1: In binary mode, with width W chosen by `size_i` (00 = 8 bits, 01 = 16 bits, 10 = 32 bits), the low W bits of `sum_o` equal (src + dst + x_i) mod 2^W. The bits of `dst_i` above W appear unchanged in `sum_o`.
- R2: In decimal mode (`bcd_i` = 1), with valid BCD digits in bits 7:0 of both operands, bits 7:0 of `sum_o` hold the two-digit BCD value of (src + dst + x_i) mod 100. Bits 31:8 equal bits 31:8 of `dst_i`, and `c_o` is 1 exactly when the decimal sum reaches 100. `size_i` has no effect in this mode.
- R3: In binary mode, `v_o` is 1 exactly when the two operands have the same sign bit at width W and the sign bit of the result differs from it.
- R4: In binary mode, `n_o` equals bit W-1 of the result.
- R5: `z_o` is 1 only when `z_i` was 1 and the result field (W bits in binary mode, 8 bits in decimal mode) is all zero. A zero result never sets it.
- R6: `x_o` always equals `c_o`.
- R7: In binary mode, `c_o` is the carry out of bit W-1.
- R8: `out_valid` rises one clock after a cycle with `in_valid` = 1. While `in_valid` is low, `sum_o` and the flags hold their values. After reset, `out_valid`, `sum_o` and all flags are 0.
- R9: A `size_i` of 11 selects the full 32-bit width, the same as 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept a request this cycle |
| src_i | input | 32 | Source operand |
| dst_i | input | 32 | Destination operand |
| size_i | input | 2 | Binary width: 00 byte, 01 word, 10/11 longword |
| bcd_i | input | 1 | 1 selects packed-decimal byte addition |
| x_i | input | 1 | Incoming extend bit, added into the sum |
| z_i | input | 1 | Incoming zero flag from the previous chain step |
| out_valid | output | 1 | Result registered from the previous cycle's request |
| sum_o | output | 32 | Sum merged into the destination's upper bits |
| x_o | output | 1 | Outgoing extend flag |
| n_o | output | 1 | Negative flag (binary mode) |
| z_o | output | 1 | Sticky zero flag |
| v_o | output | 1 | Signed overflow flag (binary mode) |
| c_o | output | 1 | Carry flag |

## Verification
The only state in the unit is its single result register, so a fault shows on the outputs on the clock after the request that exposes it. A lane chosen for the wrong width would corrupt the passed-through upper destination bits or move the carry and sign to the wrong bit. A missed decimal correction on either digit gives a non-BCD low byte or the wrong carry on inputs such as 99+01 or 58+46+1. A zero flag that is not sticky shows up as `z_o` set after a chain step whose `z_i` was clear. A register that fails to hold shows up as outputs that change during idle cycles.

// File: rtl/xadd_pkg.sv
package xadd_pkg;

    localparam int DATA_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 16;
    localparam int NIB_W   = 4;
    localparam int N_LANES = 3;
    localparam int N_DIGS  = BYTE_W / NIB_W;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_LONG  = 2'b10,
        SZ_LONG2 = 2'b11
    } size_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        ccr_t              flags;
    } result_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              carry;
        logic              ovf;
        logic              neg;
        logic              zero;
    } lane_out_t;

    // Correct one raw digit sum (0..19): add 6 when above 9.
    // Bit NIB_W of the return value is the decimal carry.
    function automatic logic [NIB_W:0] dec_fix(input logic [NIB_W:0] raw);
        logic [NIB_W:0] adj;
        if (raw > 5'd9) begin
            adj = raw + 5'd6;
            return {1'b1, adj[NIB_W-1:0]};
        end
        return {1'b0, raw[NIB_W-1:0]};
    endfunction

    function automatic int unsigned lane_index(input size_e sz);
        case (sz)
            SZ_BYTE: return 0;
            SZ_WORD: return 1;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/xadd_bin.sv
module xadd_bin
    import xadd_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] dst,
    input  size_e         size,
    input  logic          x_in,
    output lane_out_t     res
);
    logic [N_LANES-1:0] lane_c;
    logic [N_LANES-1:0] lane_v;
    logic [N_LANES-1:0] lane_n;
    logic [N_LANES-1:0] lane_z;
    logic [DW-1:0]      lane_val [N_LANES];

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int W = BYTE_W << g;
        logic [W:0] full;

        assign full      = {1'b0, src[W-1:0]} + {1'b0, dst[W-1:0]} + {{W{1'b0}}, x_in};
        assign lane_c[g] = full[W];
        assign lane_n[g] = full[W-1];
        assign lane_v[g] = (src[W-1] == dst[W-1]) && (full[W-1] != src[W-1]);
        assign lane_z[g] = (full[W-1:0] == '0);

        if (W < DW) begin : g_merge
            assign lane_val[g] = {dst[DW-1:W], full[W-1:0]};
        end else begin : g_full
            assign lane_val[g] = full[DW-1:0];
        end
    end

    int unsigned sel;

    always_comb begin
        sel       = lane_index(size);
        res.value = lane_val[sel];
        res.carry = lane_c[sel];
        res.ovf   = lane_v[sel];
        res.neg   = lane_n[sel];
        res.zero  = lane_z[sel];
    end

endmodule

// File: rtl/xadd_bcd.sv
module xadd_bcd
    import xadd_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] dst,
    input  logic          x_in,
    output lane_out_t     res
);
    logic [N_DIGS:0]      chain;
    logic [BYTE_W-1:0]    digits;

    assign chain[0] = x_in;

    for (genvar d = 0; d < N_DIGS; d++) begin : g_dig
        logic [NIB_W:0] raw;
        logic [NIB_W:0] fixed;

        assign raw   = {1'b0, src[d*NIB_W +: NIB_W]} + {1'b0, dst[d*NIB_W +: NIB_W]}
                     + {{NIB_W{1'b0}}, chain[d]};
        assign fixed = dec_fix(raw);
        assign digits[d*NIB_W +: NIB_W] = fixed[NIB_W-1:0];
        assign chain[d+1] = fixed[NIB_W];
    end

    always_comb begin
        res.value = {dst[DW-1:BYTE_W], digits};
        res.carry = chain[N_DIGS];
        // Sign and overflow carry no meaning for decimal sums; report the
        // top bit and a clear overflow so the outputs stay deterministic.
        res.ovf   = 1'b0;
        res.neg   = digits[BYTE_W-1];
        res.zero  = (digits == '0);
    end

endmodule

// File: rtl/xadd_ccr.sv
module xadd_ccr
    import xadd_pkg::*;
(
    input  logic      use_dec,
    input  lane_out_t bin_res,
    input  lane_out_t dec_res,
    input  logic      z_in,
    output result_t   nxt
);
    lane_out_t pick;

    always_comb begin
        pick          = use_dec ? dec_res : bin_res;
        nxt.value     = pick.value;
        nxt.flags.c   = pick.carry;
        nxt.flags.x   = pick.carry;
        nxt.flags.v   = pick.ovf;
        nxt.flags.n   = pick.neg;
        nxt.flags.z   = z_in & pick.zero;
    end

endmodule

// File: rtl/xadd_unit.sv
module xadd_unit
    import xadd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [1:0]        size_i,
    input  logic              bcd_i,
    input  logic              x_i,
    input  logic              z_i,
    output logic              out_valid,
    output logic [DATA_W-1:0] sum_o,
    output logic              x_o,
    output logic              n_o,
    output logic              z_o,
    output logic              v_o,
    output logic              c_o
);
    size_e     size_q;
    lane_out_t bin_res;
    lane_out_t dec_res;
    result_t   nxt;
    result_t   held;
    logic      vld_q;

    assign size_q = size_e'(size_i);

    xadd_bin #(.DW(DATA_W)) u_bin (
        .src  (src_i),
        .dst  (dst_i),
        .size (size_q),
        .x_in (x_i),
        .res  (bin_res)
    );

    xadd_bcd #(.DW(DATA_W)) u_bcd (
        .src  (src_i),
        .dst  (dst_i),
        .x_in (x_i),
        .res  (dec_res)
    );

    xadd_ccr u_ccr (
        .use_dec (bcd_i),
        .bin_res (bin_res),
        .dec_res (dec_res),
        .z_in    (z_i),
        .nxt     (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            held  <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                held <= nxt;
            end
        end
    end

    assign out_valid = vld_q;
    assign sum_o     = held.value;
    assign x_o       = held.flags.x;
    assign n_o       = held.flags.n;
    assign z_o       = held.flags.z;
    assign v_o       = held.flags.v;
    assign c_o       = held.flags.c;

endmodule

// File: rtl/xadd_chk.sv
module xadd_chk
    import xadd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] src_i,
    input logic [DATA_W-1:0] dst_i,
    input logic [1:0]        size_i,
    input logic              bcd_i,
    input logic              z_i,
    input logic              out_valid,
    input logic [DATA_W-1:0] sum_o,
    input logic              x_o,
    input logic              z_o,
    input logic              v_o,
    input logic              c_o
);
    p_x_follows_c_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (x_o == c_o));

    p_zero_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !z_i) |=> !z_o);

    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(sum_o) && $stable(c_o) && $stable(z_o) && !out_valid));

    p_byte_upper_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !bcd_i && size_i == 2'b00) |=> (sum_o[31:8] == $past(dst_i[31:8])));

    p_dec_upper_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bcd_i) |=> (sum_o[31:8] == $past(dst_i[31:8])));

    p_long_ovf_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !bcd_i && size_i[1]) |=>
        (v_o == (($past(src_i[31]) == $past(dst_i[31])) && (sum_o[31] != $past(src_i[31])))));

endmodule

bind xadd_unit xadd_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .src_i     (src_i),
    .dst_i     (dst_i),
    .size_i    (size_i),
    .bcd_i     (bcd_i),
    .z_i       (z_i),
    .out_valid (out_valid),
    .sum_o     (sum_o),
    .x_o       (x_o),
    .z_o       (z_o),
    .v_o       (v_o),
    .c_o       (c_o)
);

// File: tb/sim_xadd_unit.sv
`timescale 1ns/1ps
module sim_xadd_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] src_i, dst_i;
    logic [1:0]  size_i;
    logic        bcd_i, x_i, z_i;
    logic        out_valid;
    logic [31:0] sum_o;
    logic        x_o, n_o, z_o, v_o, c_o;

    int n_total = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    xadd_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_i(src_i), .dst_i(dst_i),
        .size_i(size_i), .bcd_i(bcd_i), .x_i(x_i), .z_i(z_i), .out_valid(out_valid),
        .sum_o(sum_o), .x_o(x_o), .n_o(n_o), .z_o(z_o), .v_o(v_o), .c_o(c_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request on a falling edge; results are sampled one full cycle later.
    task automatic issue(input logic [31:0] s, input logic [31:0] d, input logic [1:0] sz,
                         input logic dec, input logic x, input logic z);
        @(negedge clk);
        src_i = s; dst_i = d; size_i = sz; bcd_i = dec; x_i = x; z_i = z; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Binary expectation from R1, R3, R4, R5, R6, R7, R9.
    task automatic bin_case(input string name, input logic [31:0] s, input logic [31:0] d,
                            input logic [1:0] sz, input logic x, input logic z);
        int w;
        logic [32:0] full;
        logic [31:0] mask, res, exp_sum;
        logic ec, en, ev, ez;
        w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
        full = {1'b0, s & mask} + {1'b0, d & mask} + {32'd0, x};
        res  = full[31:0] & mask;
        ec   = (w == 32) ? full[32] : full[w];
        en   = res[w-1];
        ev   = (s[w-1] == d[w-1]) && (res[w-1] != s[w-1]);
        ez   = z && (res == 0);
        exp_sum = (d & ~mask) | res;
        issue(s, d, sz, 1'b0, x, z);
        check({name, " R1 sum"}, sum_o, exp_sum);
        check({name, " R7 carry"}, {31'd0, c_o}, {31'd0, ec});
        check({name, " R6 x"}, {31'd0, x_o}, {31'd0, ec});
        check({name, " R4 neg"}, {31'd0, n_o}, {31'd0, en});
        check({name, " R3 ovf"}, {31'd0, v_o}, {31'd0, ev});
        check({name, " R5 zero"}, {31'd0, z_o}, {31'd0, ez});
        check({name, " R8 valid"}, {31'd0, out_valid}, 32'd1);
    endtask

    // Decimal expectation from R2, R5, R6.
    task automatic dec_case(input string name, input logic [31:0] s, input logic [31:0] d,
                            input logic [1:0] sz, input logic x, input logic z);
        int a, b, t;
        logic [7:0] bcd;
        a = 10 * s[7:4] + s[3:0];
        b = 10 * d[7:4] + d[3:0];
        t = a + b + x;
        bcd = {4'((t % 100) / 10), 4'(t % 10)};
        issue(s, d, sz, 1'b1, x, z);
        check({name, " R2 sum"}, sum_o, {d[31:8], bcd});
        check({name, " R2 carry"}, {31'd0, c_o}, {31'd0, t >= 100});
        check({name, " R6 x"}, {31'd0, x_o}, {31'd0, t >= 100});
        check({name, " R5 zero"}, {31'd0, z_o}, {31'd0, z && (bcd == 0)});
    endtask

    task automatic t_reset;
        check("reset R8 valid", {31'd0, out_valid}, 32'd0);
        check("reset R8 sum", sum_o, 32'd0);
        check("reset R8 flags", {27'd0, x_o, n_o, z_o, v_o, c_o}, 32'd0);
    endtask

    task automatic t_binary;
        bin_case("byte carry",    32'h0000_00FF, 32'hAABB_CC01, 2'b00, 1'b0, 1'b1);
        bin_case("byte ovf",      32'h0000_007F, 32'h1234_5601, 2'b00, 1'b0, 1'b0);
        bin_case("word x in",     32'h0000_FFFF, 32'h1234_0001, 2'b01, 1'b1, 1'b1);
        bin_case("word neg ovf",  32'h0000_7000, 32'h0000_1000, 2'b01, 1'b0, 1'b1);
        bin_case("long zero",     32'h8000_0000, 32'h8000_0000, 2'b10, 1'b0, 1'b1);
        bin_case("long R9 alias", 32'h7FFF_FFFF, 32'h0000_0000, 2'b11, 1'b1, 1'b1);
        bin_case("long plain",    32'h1234_5678, 32'h1111_1111, 2'b10, 1'b0, 1'b1);
    endtask

    task automatic t_sticky_zero;
        // Zero result with z_i clear: R5 says z_o stays clear.
        bin_case("sticky R5", 32'h0000_0001, 32'h0000_00FF, 2'b00, 1'b0, 1'b0);
    endtask

    task automatic t_decimal;
        dec_case("dec 45+38",    32'h0000_0045, 32'h0000_0038, 2'b00, 1'b0, 1'b1);
        dec_case("dec 99+01",    32'h0000_0099, 32'h0000_0001, 2'b00, 1'b0, 1'b1);
        dec_case("dec 58+46+1",  32'h0000_0058, 32'h0000_0046, 2'b00, 1'b1, 1'b1);
        dec_case("dec size word", 32'hFFFF_FF19, 32'hDEAD_BE27, 2'b01, 1'b0, 1'b0);
        dec_case("dec size long", 32'h0000_0000, 32'h0000_0099, 2'b10, 1'b1, 1'b1);
    endtask

    // Four-digit decimal chain 5099 + 4901, flags carried between steps.
    task automatic t_chain;
        logic cx, cz;
        issue(32'h99, 32'h01, 2'b00, 1'b1, 1'b0, 1'b1);
        check("chain lo R2", sum_o, 32'h0000_0000);
        cx = x_o; cz = z_o;
        issue(32'h50, 32'h49, 2'b00, 1'b1, cx, cz);
        check("chain hi R2", sum_o, 32'h0000_0000);
        check("chain R2 carry", {31'd0, c_o}, 32'd1);
        check("chain R5 zero", {31'd0, z_o}, 32'd1);
    endtask

    task automatic t_hold;
        logic [31:0] s0;
        s0 = sum_o;
        src_i = 32'hFFFF_FFFF; dst_i = 32'h1; size_i = 2'b10; x_i = 1'b1;
        repeat (3) @(negedge clk);
        check("hold R8 sum", sum_o, s0);
        check("hold R8 valid", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; src_i = '0; dst_i = '0; size_i = '0;
        bcd_i = 1'b0; x_i = 1'b0; z_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_binary();
        t_sticky_zero();
        t_decimal();
        t_chain();
        t_hold();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule